// File: doc/BRIEF.md
# Burst Column Address Generator

This block sits beside a DRAM command sequencer and turns each column command into the list of column addresses that the burst will touch. It keeps its own copy of the burst-related fields of the device mode register. The copy is updated when a mode-register-set strobe arrives with bank address zero while every bank is idle. From that copy it takes the burst length (2, 4, 8 or 16 beats), the burst order (linear wrap or XOR), and the CAS latency, which it reports to the rest of the controller.

A pulse on `burst_start` captures the start column, and the block then offers one column address per beat on a valid/ready stream. Back-pressure rules: `col_valid` stays high from the cycle after `burst_start` until the final beat is accepted. While `col_valid` is high and `col_ready` is low, the address and the last-beat flag hold their values. A beat is consumed only on a clock edge where both signals are high. `burst_start` has priority over everything else. It discards the remaining beats of a running burst, including any beat that is handshaken in the same cycle, and restarts from beat zero.

If a mode write carries a reserved length or latency code, the block raises a sticky error flag and keeps the previous value of that field. The other fields of the same write are still applied.

Top module: `burst_colgen`

## Requirements
- R1: A mode write takes effect only on a clock edge where `mrs_en` is 1, `bank_addr` is 0 and `banks_idle` is 1. Any other `mrs_en` pulse leaves the burst length, the order and `cas_lat` unchanged.
- R2: Mode field `addr[2:0]` sets the burst length: 001 gives 2 beats, 010 gives 4, 011 gives 8 and 100 gives 16.
- R3: Mode bit `addr[3]` sets the order: 0 is sequential (linear wrap) and 1 is interleaved (XOR).
- R4: Mode field `addr[6:4]` sets the latency: 010 gives `cas_lat`=2 and 011 gives `cas_lat`=3.
- R5: A reserved length code (000, 101, 110, 111) or a reserved latency code (anything other than 010 or 011) sets `mode_err`, which stays at 1 until reset. The affected field keeps its previous value, and the legal fields of the same write are still applied.
- R6: In sequential order, beat k has the address bits below log2(BL) equal to (start + k) mod BL. The upper bits equal those of the start column.
- R7: In interleaved order, beat k has the address bits below log2(BL) equal to the start's low bits XOR k. The upper bits equal those of the start column.
- R8: `col_last` is 1 exactly on beat BL-1. After that beat is accepted, `col_valid` is 0 on the next cycle unless a new burst starts.
- R9: While `col_valid` is 1 and `col_ready` is 0, `col_addr` and `col_last` hold their values and `col_valid` stays at 1.
- R10: `burst_start` during a burst restarts the sequence at beat 0 from the new start column, using the mode in force at that edge.
- R11: After reset, `col_valid`=0, `mode_err`=0, `cas_lat`=3, and the mode is 2-beat sequential.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mrs_en | input | 1 | Mode-register-set command strobe |
| bank_addr | input | BA_W (2) | Bank address presented with the command |
| addr | input | ADDR_W (13) | Address bus; [6:0] carries the mode word |
| banks_idle | input | 1 | High when every bank is precharged |
| burst_start | input | 1 | READ or WRITE issued: start a burst |
| start_col | input | COL_W (10) | Column address of the first beat |
| col_ready | input | 1 | Consumer accepts the current beat |
| col_valid | output | 1 | A beat address is offered |
| col_addr | output | COL_W (10) | Column address of the current beat |
| col_last | output | 1 | Current beat is the final one of the burst |
| cas_lat | output | 2 | Programmed CAS latency (2 or 3) |
| mode_err | output | 1 | Sticky flag: a reserved mode code was written |

## Verification
Assertions check these properties on every cycle:
- the beat counter holds under back-pressure;
- the stream ends after an accepted last beat;
- a start always restarts at beat zero;
- the upper column bits never change within a burst;
- the error flag is sticky;
- the latency stays legal;
- the mode is unchanged when no write is accepted.

The actual address orderings (wrap position for each burst length, XOR patterns) can only be shown by the bench scenarios, compared against an independent reference model. The same applies to keeping a field while applying its neighbours on a partly reserved write, and to ignoring writes that arrive with a non-zero bank or with busy banks.

// File: rtl/colgen_pkg.sv
package colgen_pkg;

  // Longest burst is 2**MAX_LEN_LOG beats
  localparam int MAX_LEN_LOG = 4;
  localparam int LEN_LOG_W   = 3;

  typedef enum logic {
    ORDER_SEQ = 1'b0,
    ORDER_XOR = 1'b1
  } order_e;

  typedef struct packed {
    logic [LEN_LOG_W-1:0] len_log;  // log2 of burst length
    order_e               order;
    logic [1:0]           lat;      // CAS latency in clocks
  } mode_t;

  localparam mode_t MODE_RESET = '{len_log: 3'd1, order: ORDER_SEQ, lat: 2'd3};

  // Length code equals log2(length) for the legal codes 1..4
  function automatic logic len_code_ok(input logic [2:0] code);
    return (code >= 3'd1) && (code <= 3'd4);
  endfunction

  function automatic logic lat_code_ok(input logic [2:0] code);
    return (code == 3'd2) || (code == 3'd3);
  endfunction

endpackage

// File: rtl/colgen_mode_reg.sv
module colgen_mode_reg
  import colgen_pkg::*;
#(
  parameter int BA_W = 2
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            wr_req,
  input  logic [BA_W-1:0] bank,
  input  logic            idle,
  input  logic [6:0]      code,
  output mode_t           mode_o,
  output logic            err_o
);

  mode_t mode_q;
  logic  err_q;
  logic  wr_ok;
  logic  len_ok;
  logic  lat_ok;

  assign wr_ok  = wr_req && (bank == '0) && idle;
  assign len_ok = len_code_ok(code[2:0]);
  assign lat_ok = lat_code_ok(code[6:4]);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q <= MODE_RESET;
      err_q  <= 1'b0;
    end else if (wr_ok) begin
      if (len_ok) mode_q.len_log <= code[2:0];
      mode_q.order <= order_e'(code[3]);
      if (lat_ok) mode_q.lat <= code[5:4];
      if (!len_ok || !lat_ok) err_q <= 1'b1;
    end
  end

  assign mode_o = mode_q;
  assign err_o  = err_q;

  // R1: no accepted write, no change
  a_r1_ignore_write: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_req && (bank == '0) && idle) |=> $stable(mode_o));

  // R5: error flag never clears
  a_r5_err_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    err_o |=> err_o);

  // R4: latency always one of the legal values
  a_r4_lat_legal: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_o.lat == 2'd2) || (mode_o.lat == 2'd3));

  // R5: a reserved length code keeps the old length
  a_r5_len_kept: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_ok && !len_code_ok(code[2:0])) |=> $stable(mode_o.len_log) && err_o);

endmodule

// File: rtl/colgen_beat_seq.sv
module colgen_beat_seq
  import colgen_pkg::*;
#(
  parameter int BEAT_W = MAX_LEN_LOG
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 start,
  input  logic [LEN_LOG_W-1:0] len_log,
  input  logic                 ready,
  output logic                 active_o,
  output logic [BEAT_W-1:0]    beat_o,
  output logic [BEAT_W-1:0]    mask_o,
  output logic                 last_o
);

  logic                 active_q;
  logic [BEAT_W-1:0]    beat_q;
  logic [LEN_LOG_W-1:0] len_q;
  logic [BEAT_W:0]      span;
  logic [BEAT_W:0]      span_m1;

  assign span    = (BEAT_W+1)'(1) << len_q;
  assign span_m1 = span - (BEAT_W+1)'(1);
  assign mask_o  = span_m1[BEAT_W-1:0];
  assign last_o  = active_q && (beat_q == mask_o);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active_q <= 1'b0;
      beat_q   <= '0;
      len_q    <= LEN_LOG_W'(1);
    end else if (start) begin
      active_q <= 1'b1;
      beat_q   <= '0;
      len_q    <= len_log;
    end else if (active_q && ready) begin
      if (last_o) begin
        active_q <= 1'b0;
        beat_q   <= '0;
      end else begin
        beat_q <= beat_q + 1'b1;
      end
    end
  end

  assign active_o = active_q;
  assign beat_o   = beat_q;

  // R9: stalled beat holds
  a_r9_hold_on_stall: assert property (@(posedge clk) disable iff (!rst_n)
    (active_o && !ready && !start) |=> active_o && $stable(beat_o));

  // R8: stream ends after accepted last beat
  a_r8_end_after_last: assert property (@(posedge clk) disable iff (!rst_n)
    (last_o && ready && !start) |=> !active_o);

  // R10: a start always lands on beat zero
  a_r10_restart_zero: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> active_o && (beat_o == '0));

endmodule

// File: rtl/colgen_addr_map.sv
module colgen_addr_map
  import colgen_pkg::*;
#(
  parameter int COL_W  = 10,
  parameter int BEAT_W = MAX_LEN_LOG
) (
  input  logic [COL_W-1:0]  base,
  input  logic [BEAT_W-1:0] beat,
  input  logic [BEAT_W-1:0] mask,
  input  order_e            order,
  output logic [COL_W-1:0]  col
);

  logic [BEAT_W-1:0] low_seq;
  logic [BEAT_W-1:0] low_xor;
  logic [BEAT_W-1:0] low_sel;

  assign low_seq = base[BEAT_W-1:0] + beat;
  assign low_xor = base[BEAT_W-1:0] ^ beat;
  assign low_sel = (order == ORDER_XOR) ? low_xor : low_seq;

  for (genvar g = 0; g < COL_W; g++) begin : g_bit
    if (g < BEAT_W) begin : g_low
      assign col[g] = mask[g] ? low_sel[g] : base[g];
    end else begin : g_high
      assign col[g] = base[g];
    end
  end

endmodule

// File: rtl/burst_colgen.sv
module burst_colgen
  import colgen_pkg::*;
#(
  parameter int COL_W  = 10,
  parameter int ADDR_W = 13,
  parameter int BA_W   = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              mrs_en,
  input  logic [BA_W-1:0]   bank_addr,
  input  logic [ADDR_W-1:0] addr,
  input  logic              banks_idle,
  input  logic              burst_start,
  input  logic [COL_W-1:0]  start_col,
  input  logic              col_ready,
  output logic              col_valid,
  output logic [COL_W-1:0]  col_addr,
  output logic              col_last,
  output logic [1:0]        cas_lat,
  output logic              mode_err
);

  localparam int BEAT_W = MAX_LEN_LOG;

  mode_t             mode;
  logic [COL_W-1:0]  base_q;
  order_e            order_q;
  logic [BEAT_W-1:0] beat;
  logic [BEAT_W-1:0] mask;
  logic [COL_W-1:0]  mask_ext;

  colgen_mode_reg #(.BA_W(BA_W)) u_mode (
    .clk    (clk),
    .rst_n  (rst_n),
    .wr_req (mrs_en),
    .bank   (bank_addr),
    .idle   (banks_idle),
    .code   (addr[6:0]),
    .mode_o (mode),
    .err_o  (mode_err)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      base_q  <= '0;
      order_q <= ORDER_SEQ;
    end else if (burst_start) begin
      base_q  <= start_col;
      order_q <= mode.order;
    end
  end

  colgen_beat_seq #(.BEAT_W(BEAT_W)) u_seq (
    .clk      (clk),
    .rst_n    (rst_n),
    .start    (burst_start),
    .len_log  (mode.len_log),
    .ready    (col_ready),
    .active_o (col_valid),
    .beat_o   (beat),
    .mask_o   (mask),
    .last_o   (col_last)
  );

  colgen_addr_map #(.COL_W(COL_W), .BEAT_W(BEAT_W)) u_map (
    .base  (base_q),
    .beat  (beat),
    .mask  (mask),
    .order (order_q),
    .col   (col_addr)
  );

  assign cas_lat  = mode.lat;
  assign mask_ext = COL_W'(mask);

  // R6 / R7: upper column bits fixed across the beats of one burst
  a_r6_upper_fixed: assert property (@(posedge clk) disable iff (!rst_n)
    (col_valid && !burst_start) |=>
      (!col_valid || ((col_addr & ~mask_ext) == $past(col_addr & ~mask_ext))));

  // R9: stalled output holds at the port
  a_r9_port_stable: assert property (@(posedge clk) disable iff (!rst_n)
    (col_valid && !col_ready && !burst_start) |=>
      col_valid && $stable(col_addr) && $stable(col_last));

endmodule

// File: tb/burst_colgen_bench.sv
`timescale 1ns/1ps
module burst_colgen_bench;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        mrs_en = 1'b0;
  logic [1:0]  bank_addr = '0;
  logic [12:0] addr = '0;
  logic        banks_idle = 1'b1;
  logic        burst_start = 1'b0;
  logic [9:0]  start_col = '0;
  logic        col_ready = 1'b1;
  logic        col_valid;
  logic [9:0]  col_addr;
  logic        col_last;
  logic [1:0]  cas_lat;
  logic        mode_err;

  always #2.5 clk = ~clk;

  burst_colgen u_burst_colgen (
    .clk(clk), .rst_n(rst_n), .mrs_en(mrs_en), .bank_addr(bank_addr),
    .addr(addr), .banks_idle(banks_idle), .burst_start(burst_start),
    .start_col(start_col), .col_ready(col_ready), .col_valid(col_valid),
    .col_addr(col_addr), .col_last(col_last), .cas_lat(cas_lat),
    .mode_err(mode_err)
  );

  // Reference model state
  int m_bl = 2, m_order = 0, m_cl = 3, m_err = 0;
  int m_act = 0, m_beat = 0, m_start = 0, m_len = 2, m_il = 0;
  int n_cmp = 0, n_bad = 0, cyc = 0;
  bit done = 0;
  string tag = "R11";

  always @(posedge clk) begin
    if (!rst_n) begin
      m_bl = 2; m_order = 0; m_cl = 3; m_err = 0; m_act = 0; m_beat = 0;
    end else begin
      if (burst_start) begin
        m_act = 1; m_beat = 0; m_start = start_col; m_len = m_bl; m_il = m_order;
      end else if (m_act != 0 && col_ready) begin
        if (m_beat == m_len - 1) m_act = 0;
        else m_beat++;
      end
      if (mrs_en && bank_addr == 0 && banks_idle) begin
        if (addr[2:0] >= 1 && addr[2:0] <= 4) m_bl = 1 << addr[2:0];
        else m_err = 1;
        m_order = addr[3];
        if (addr[6:4] == 3'd2) m_cl = 2;
        else if (addr[6:4] == 3'd3) m_cl = 3;
        else m_err = 1;
      end
    end
  end

  function automatic int exp_addr();
    int a;
    if (m_il != 0) a = m_start ^ m_beat;
    else a = (m_start & ~(m_len - 1)) | ((m_start + m_beat) & (m_len - 1));
    return a & 10'h3FF;
  endfunction

  task automatic summary();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  always @(negedge clk) begin
    if (!done) begin
      int ea; bit el; bit bad;
      cyc++;
      ea = exp_addr();
      el = (m_act != 0) && (m_beat == m_len - 1);
      bad = (col_valid !== (m_act != 0)) || (cas_lat !== 2'(m_cl)) ||
            (mode_err !== (m_err != 0)) ||
            ((m_act != 0) && ((col_addr !== 10'(ea)) || (col_last !== el))) ||
            ((m_act == 0) && (col_last !== 1'b0));
      n_cmp++;
      if (bad) begin
        n_bad++;
        $display("FAIL %s cyc %0d: got v=%0b a=%h l=%0b cl=%0d e=%0b exp v=%0d a=%h l=%0b cl=%0d e=%0d",
                 tag, cyc, col_valid, col_addr, col_last, cas_lat, mode_err,
                 m_act, ea, el, m_cl, m_err);
      end
      if (cyc > 20000) begin
        n_bad++;
        $display("FAIL watchdog: got running exp finished");
        done = 1;
        summary();
      end
    end
  end

  task automatic tick();
    @(posedge clk); #1;
  endtask

  task automatic mode_write(input logic [6:0] code, input logic [1:0] ba, input logic idle);
    mrs_en = 1; addr = {6'b0, code}; bank_addr = ba; banks_idle = idle;
    tick();
    mrs_en = 0; bank_addr = 0; banks_idle = 1; addr = '0;
  endtask

  // pat 0: always ready; pat 1: stall every third cycle
  task automatic burst(input logic [9:0] col, input int cycles, input int pat);
    burst_start = 1; start_col = col; col_ready = 1;
    tick();
    burst_start = 0;
    for (int k = 0; k < cycles; k++) begin
      col_ready = (pat == 0) ? 1'b1 : ((k % 3) != 1);
      tick();
    end
    col_ready = 1;
  endtask

  initial begin
    tag = "R11"; // reset state
    repeat (3) tick();
    rst_n = 1;
    repeat (2) tick();

    tag = "R6";  // default 2-beat sequential, wrap from odd start
    burst(10'h005, 4, 0);

    tag = "R2";  // BL8 sequential, CL2 (R4)
    mode_write(7'b010_0_011, 2'd0, 1'b1);
    tag = "R6";
    burst(10'h01D, 10, 0);

    tag = "R7";  // BL16 interleaved, CL3 (R3, R4)
    mode_write(7'b011_1_100, 2'd0, 1'b1);
    burst(10'h2A7, 18, 0);

    tag = "R9";  // BL4 interleaved under back-pressure
    mode_write(7'b011_1_010, 2'd0, 1'b1);
    burst(10'h10E, 12, 1);

    tag = "R10"; // restart mid burst, then change order on restart
    mode_write(7'b010_0_011, 2'd0, 1'b1);
    burst(10'h0F3, 3, 0);
    burst(10'h1C9, 3, 1);
    mode_write(7'b010_1_011, 2'd0, 1'b1);
    burst(10'h07A, 10, 0);

    tag = "R1";  // writes with non-zero bank or busy banks are ignored
    mode_write(7'b011_0_001, 2'd1, 1'b1);
    mode_write(7'b011_0_001, 2'd0, 1'b0);
    burst(10'h033, 10, 0);

    tag = "R5";  // reserved length, legal latency and order applied
    mode_write(7'b011_0_111, 2'd0, 1'b1);
    burst(10'h2EE, 10, 0);
    mode_write(7'b110_1_010, 2'd0, 1'b1); // reserved latency, length 4
    burst(10'h121, 6, 0);
    mode_write(7'b010_0_000, 2'd0, 1'b1);
    burst(10'h3FF, 6, 0);

    tag = "R8";  // back-to-back bursts on the last beat
    mode_write(7'b011_0_001, 2'd0, 1'b1);
    burst(10'h100, 1, 0);
    burst(10'h101, 4, 0);

    repeat (3) tick();
    done = 1;
    summary();
  end

endmodule